// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block collects interrupt requests from ten peripheral sources and decides when the processor takes an interrupt. Each source has a request latch and a programmable level from 0 to 3. The processor also runs at a level from 0 to 3. At each instruction boundary the block copies the request latches into a pending register. At the following boundary it takes the best captured request, provided that request's level is strictly higher than the processor level.

When an interrupt is taken, the block does four things. It drives a vector address that points into a 256-byte code table, where each source owns a 16-byte slot. It raises the processor level to the level of the interrupt. It pushes the old level onto a four-entry stack of 2-bit levels. A return strobe pops that stack.

Sources 0 and 1 are the external pins. Their request is cleared only when the interrupt is acknowledged. Sources 2 to 9 are internal, and their service routines clear them with an explicit clear strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cur_level` is 3, `level_stack` is 8'hFF, all request latches are clear and `irq_take` is 0.
- R2: A `req_set[i]` pulse sets latch i. When `req_set[i]` and `req_clr[i]` are high in the same cycle, the latch ends up set.
- R3: For internal sources (indices 2 to 9), a `req_clr[i]` pulse clears the latch. If the clear comes before the latch is captured at an instruction boundary, no interrupt is ever taken for that request.
- R4: External sources (indices 0 and 1) ignore `req_clr`, and their latch is cleared when their interrupt is taken. The latch of an internal source stays set when its interrupt is taken.
- R5: An `insn_done` pulse captures the latches into the pending register. The decision to take an interrupt uses only the value captured at an earlier boundary. `irq_take` is a one-cycle pulse in the cycle after the `insn_done` edge that takes the interrupt.
- R6: An interrupt is taken only when the winning pending level is strictly greater than `cur_level`. A source programmed to level 0 is never taken.
- R7: Among captured requests, the highest level wins. Among equal levels, the lower source index wins (0 = external 1, 1 = external 0, 2 = periodic tick, 3 = timer B, 4 = timer A, 5 = slave port, 6 to 9 = serial ports A to D).
- R8: `vec_addr` = {base, source index (4 bits), 4'b0000}. The base is `ext_base` for sources 0 and 1 and `int_base` for all other sources. The value holds until the next interrupt is taken.
- R9: Taking an interrupt sets `cur_level` to the winner's level and pushes the old level into `level_stack[1:0]`. The older entries shift toward `[7:6]`.
- R10: A `reti` pulse sets `cur_level` to `level_stack[1:0]` and shifts each entry one place toward `[1:0]`. `level_stack[7:6]` keeps its value.
- R11: When `reti` and `insn_done` are high in the same cycle, the pop happens and no interrupt is taken.
- R12: A `lvl_load` pulse, when neither a pop nor a take happens in that cycle, sets `cur_level` to `lvl_value` and leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 10 | Per-source request strobes |
| req_clr | input | 10 | Per-source software clear strobes (internal sources only) |
| src_level | input | 20 | Level of source i in bits [2i+1:2i] |
| insn_done | input | 1 | Instruction-boundary strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| lvl_load | input | 1 | Load strobe for the processor level |
| lvl_value | input | 2 | Level written by `lvl_load` |
| ext_base | input | 8 | Table base for the external sources |
| int_base | input | 8 | Table base for the internal sources |
| irq_take | output | 1 | One-cycle pulse when an interrupt is taken |
| vec_addr | output | 16 | Vector address of the last interrupt taken |
| cur_level | output | 2 | Current processor level |
| level_stack | output | 8 | Saved levels, entry 0 in [1:0] |

## Verification
The bench sweeps every source against every source level and every processor level. A design that compared with `>=`, or that took level-0 sources, would then show up as spurious takes. Every pair of sources is raced at equal and at unequal levels, which catches a reversed tie order or a lower level winning. Separate sequences target the clear rules, the nested push and pop with its sticky bottom entry, and a return that lands on a boundary. A design that cleared internal latches on acknowledge, honoured a clear on an external pin, or let the clear win over a set would fail these sequences. So would one that took an interrupt in the return cycle or shifted a 0 into the stack.

// File: rtl/prio_irq_pkg.sv
// Package: shared level type and reset constant for the priority-level
// interrupt controller. Assumes the 2-bit processor level encoding 0..3.
package prio_irq_pkg;
    typedef logic [1:0] lvl_t;
    localparam lvl_t LVL_RESET = 2'd3;
endpackage

// File: rtl/irq_latch_bank.sv
// Module: per-source request latches plus the pending register that the
// central logic samples at instruction boundaries. Assumes sources below
// NUM_EXT are external (cleared by acknowledge), the rest are cleared by
// software. A set in the same cycle as a clear leaves the latch set.
module irq_latch_bank #(
    parameter int NUM_SRC = 10,
    parameter int NUM_EXT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] sw_clr_i,
    input  logic [NUM_SRC-1:0] ack_i,
    input  logic               capture_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] latch_q;
    logic [NUM_SRC-1:0] drop;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i < NUM_EXT) begin : g_ext
            assign drop[i] = ack_i[i];
        end else begin : g_int
            assign drop[i] = sw_clr_i[i];
        end
    end

    // Latch update: a set overrides a clear arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= set_i | (latch_q & ~drop);
    end

    // Pending capture at each boundary, dropping an external source being acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_o <= '0;
        else if (capture_i) pend_o <= latch_q & ~(ack_i & drop);
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module: combinational arbiter. Picks the highest-level captured request;
// equal levels go to the lowest index. Level 0 never wins.
module irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 10,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0]   pend_i,
    input  logic [2*NUM_SRC-1:0] lvl_i,
    output logic                 valid_o,
    output logic [IDX_W-1:0]     idx_o,
    output lvl_t                 lvl_o
);
    // Scan from the last source down so a lower index overrides on a tie.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i] && (lvl_i[2*i +: 2] != 2'd0) && (lvl_i[2*i +: 2] >= lvl_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                lvl_o   = lvl_i[2*i +: 2];
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
// Module: processor level and its stack of saved levels. A pop restores
// entry 0 and keeps the deepest entry. A push saves the current level.
// A load writes the level only. Priority: pop, push, load.
module irq_level_stack
    import prio_irq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_i,
    input  logic             push_i,
    input  lvl_t             push_lvl_i,
    input  logic             load_i,
    input  lvl_t             load_lvl_i,
    output lvl_t             cur_o,
    output logic [2*DEPTH-1:0] stack_o
);
    lvl_t stk_q [DEPTH];

    // Level register and stack update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o <= LVL_RESET;
            for (int k = 0; k < DEPTH; k++) stk_q[k] <= LVL_RESET;
        end else if (pop_i) begin
            cur_o <= stk_q[0];
            for (int k = 0; k < DEPTH - 1; k++) stk_q[k] <= stk_q[k+1];
        end else if (push_i) begin
            cur_o    <= push_lvl_i;
            stk_q[0] <= cur_o;
            for (int k = 1; k < DEPTH; k++) stk_q[k] <= stk_q[k-1];
        end else if (load_i) begin
            cur_o <= load_lvl_i;
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_flat
        assign stack_o[2*k +: 2] = stk_q[k];
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the priority-level interrupt controller. Ties together the
// latches, arbiter and level stack, decides the take at each boundary and
// registers the vector into the 16-byte-slot code table.
// Assumes NUM_SRC <= 2**IDX_W and that sources below NUM_EXT are external.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC   = 10,
    parameter int NUM_EXT   = 2,
    parameter int DEPTH     = 4,
    parameter int BASE_W    = 8,
    parameter int SLOT_LOG2 = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                req_set,
    input  logic [NUM_SRC-1:0]                req_clr,
    input  logic [2*NUM_SRC-1:0]              src_level,
    input  logic                              insn_done,
    input  logic                              reti,
    input  logic                              lvl_load,
    input  logic [1:0]                        lvl_value,
    input  logic [BASE_W-1:0]                 ext_base,
    input  logic [BASE_W-1:0]                 int_base,
    output logic                              irq_take,
    output logic [BASE_W+$clog2(NUM_SRC)+SLOT_LOG2-1:0] vec_addr,
    output logic [1:0]                        cur_level,
    output logic [2*DEPTH-1:0]                level_stack
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    lvl_t               win_lvl;
    logic               take;

    // Take at a boundary that is not also a return, when the winner outranks the level.
    assign take = insn_done && !reti && win_valid && (win_lvl > cur_level);

    // One-hot acknowledge of the winning source.
    always_comb begin
        ack = '0;
        if (take) ack[win_idx] = 1'b1;
    end

    irq_latch_bank #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) u_latch (
        .clk(clk), .rst_n(rst_n), .set_i(req_set), .sw_clr_i(req_clr),
        .ack_i(ack), .capture_i(insn_done), .pend_o(pend)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .pend_i(pend), .lvl_i(src_level),
        .valid_o(win_valid), .idx_o(win_idx), .lvl_o(win_lvl)
    );

    irq_level_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .pop_i(reti), .push_i(take),
        .push_lvl_i(win_lvl), .load_i(lvl_load), .load_lvl_i(lvl_value),
        .cur_o(cur_level), .stack_o(level_stack)
    );

    // Take pulse and vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take <= 1'b0;
            vec_addr <= '0;
        end else begin
            irq_take <= take;
            if (take)
                vec_addr <= {(int'(win_idx) < NUM_EXT) ? ext_base : int_base,
                             win_idx, {SLOT_LOG2{1'b0}}};
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Module: assertion checker for the controller, attached with bind.
module prio_irq_ctrl_chk #(
    parameter int DEPTH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               insn_done,
    input logic               reti,
    input logic               irq_take,
    input logic [1:0]         cur_level,
    input logic [2*DEPTH-1:0] level_stack
);
    // R5: a take only follows a boundary strobe.
    a_r5_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(insn_done));
    // R6: a take strictly raises the level.
    a_r6_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (cur_level > $past(cur_level)));
    // R9: the old level lands on top of the stack.
    a_r9_push_old_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (level_stack[1:0] == $past(cur_level)));
    // R10: a pop restores the top entry and keeps the deepest one.
    a_r10_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> (cur_level == $past(level_stack[1:0]))
              && (level_stack[2*DEPTH-1 -: 2] == $past(level_stack[2*DEPTH-1 -: 2])));
    // R11: no take in the cycle of a return.
    a_r11_no_take_on_reti: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !irq_take);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .reti(reti),
    .irq_take(irq_take), .cur_level(cur_level), .level_stack(level_stack)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] req_set = '0, req_clr = '0;
    logic [2*N-1:0] src_level = '0;
    logic        insn_done = 1'b0, reti = 1'b0, lvl_load = 1'b0;
    logic [1:0]  lvl_value = '0;
    logic [7:0]  ext_base = 8'hA5, int_base = 8'h3C;
    logic        irq_take;
    logic [15:0] vec_addr;
    logic [1:0]  cur_level;
    logic [7:0]  level_stack;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
        .src_level(src_level), .insn_done(insn_done), .reti(reti),
        .lvl_load(lvl_load), .lvl_value(lvl_value), .ext_base(ext_base),
        .int_base(int_base), .irq_take(irq_take), .vec_addr(vec_addr),
        .cur_level(cur_level), .level_stack(level_stack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; req_set = '0; req_clr = '0;
        insn_done = 0; reti = 0; lvl_load = 0; src_level = '0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic load_lvl(input logic [1:0] v);
        @(negedge clk); lvl_load = 1; lvl_value = v;
        @(negedge clk); lvl_load = 0;
    endtask

    task automatic set_src(input int i);
        @(negedge clk); req_set[i] = 1;
        @(negedge clk); req_set[i] = 0;
    endtask

    task automatic clr_src(input int i);
        @(negedge clk); req_clr[i] = 1;
        @(negedge clk); req_clr[i] = 0;
    endtask

    // Pulse a boundary; irq_take is sampled in the cycle after the edge.
    task automatic boundary(output logic took);
        @(negedge clk); insn_done = 1;
        @(negedge clk); insn_done = 0; took = irq_take;
    endtask

    task automatic do_reti();
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0;
    endtask

    function automatic logic [15:0] exp_vec(input int i);
        return {(i < 2) ? ext_base : int_base, 4'(i), 4'h0};
    endfunction

    initial begin : wd
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic t;
        // R1 reset state
        do_reset();
        @(negedge clk);
        chk("R1 cur_level", cur_level, 3);
        chk("R1 stack", level_stack, 8'hFF);
        chk("R1 irq_take", irq_take, 0);
        boundary(t); boundary(t);
        chk("R1 latches clear", t, 0);

        // R6 R8 R9 sweep: source x source level x processor level
        for (int i = 0; i < N; i++)
            for (int l = 0; l < 4; l++)
                for (int c = 0; c < 4; c++) begin
                    do_reset();
                    load_lvl(2'(c));
                    src_level[2*i +: 2] = 2'(l);
                    set_src(i);
                    boundary(t);
                    chk("R5 no take at capture", t, 0);
                    boundary(t);
                    chk("R6 take decision", t, (l > c) ? 1 : 0);
                    if (l > c) begin
                        chk("R8 vector", vec_addr, exp_vec(i));
                        chk("R9 new level", cur_level, l);
                        chk("R9 pushed level", level_stack, {6'h3F, 2'(c)});
                    end else begin
                        chk("R12 level kept", cur_level, c);
                    end
                end

        // R7 pairwise races
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++) begin
                do_reset(); load_lvl(0);
                src_level[2*i +: 2] = 2; src_level[2*j +: 2] = 2;
                @(negedge clk); req_set[i] = 1; req_set[j] = 1;
                @(negedge clk); req_set = '0;
                boundary(t); boundary(t);
                chk("R7 tie lower index", vec_addr, exp_vec(i));
                do_reset(); load_lvl(0);
                src_level[2*i +: 2] = 1; src_level[2*j +: 2] = 3;
                @(negedge clk); req_set[i] = 1; req_set[j] = 1;
                @(negedge clk); req_set = '0;
                boundary(t); boundary(t);
                chk("R7 higher level wins", vec_addr, exp_vec(j));
                chk("R7 level", cur_level, 3);
            end

        // R3 clear before capture loses the request
        do_reset(); load_lvl(0); src_level[2*7 +: 2] = 1;
        set_src(7); clr_src(7);
        boundary(t); boundary(t);
        chk("R3 cleared request lost", t, 0);

        // R2 set wins over clear in the same cycle
        do_reset(); load_lvl(0); src_level[2*3 +: 2] = 1;
        @(negedge clk); req_set[3] = 1; req_clr[3] = 1;
        @(negedge clk); req_set = '0; req_clr = '0;
        boundary(t); boundary(t);
        chk("R2 set beats clear", t, 1);

        // R4 external ignores clear, cleared by acknowledge
        do_reset(); load_lvl(0); src_level[2*1 +: 2] = 2;
        set_src(1); clr_src(1);
        boundary(t); boundary(t);
        chk("R4 external clear ignored", t, 1);
        do_reti();
        chk("R10 back to 0", cur_level, 0);
        boundary(t);
        chk("R4 external acked (1)", t, 0);
        boundary(t);
        chk("R4 external acked (2)", t, 0);

        // R4 internal stays set after acknowledge
        do_reset(); load_lvl(0); src_level[2*4 +: 2] = 1;
        set_src(4); boundary(t); boundary(t);
        chk("R4 internal taken", t, 1);
        do_reti();
        boundary(t);
        chk("R4 internal retaken", t, 1);

        // R9 R10 nesting
        do_reset(); load_lvl(0);
        src_level[2*9 +: 2] = 1; src_level[2*5 +: 2] = 2; src_level[2*0 +: 2] = 3;
        set_src(9); boundary(t); boundary(t);
        chk("R9 nest1 stack", level_stack, 8'hFC);
        set_src(5); boundary(t); boundary(t);
        chk("R9 nest2 stack", level_stack, 8'hF1);
        set_src(0); boundary(t); boundary(t);
        chk("R9 nest3 stack", level_stack, 8'hC6);
        chk("R9 nest3 level", cur_level, 3);
        do_reti();
        chk("R10 pop1 level", cur_level, 2);
        chk("R10 pop1 stack", level_stack, 8'hF1);
        do_reti();
        chk("R10 pop2 level", cur_level, 1);
        chk("R10 pop2 stack", level_stack, 8'hFC);
        do_reti();
        chk("R10 pop3 level", cur_level, 0);
        chk("R10 bottom kept", level_stack, 8'hFF);

        // R11 return on a boundary suppresses the take
        do_reset(); load_lvl(0); src_level[2*8 +: 2] = 1;
        set_src(8); boundary(t);
        @(negedge clk); reti = 1; insn_done = 1;
        @(negedge clk); reti = 0; insn_done = 0;
        chk("R11 no take", irq_take, 0);
        chk("R11 popped level", cur_level, 3);

        // R5 capture is required: set after last boundary is not taken
        do_reset(); load_lvl(0); src_level[2*6 +: 2] = 3;
        set_src(6); boundary(t);
        chk("R5 capture only", t, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule